// File: doc/BRIEF.md
# Three-Wire Serial Byte Shifter

This block is the host end of a three-wire serial link made of a chip-enable, a clock and one bidirectional data wire. One start pulse moves one byte: a write shifts eight bits out of the data pin, and a read shifts eight bits in from it. The surrounding logic owns the chip-enable, builds the command and data bytes and orders the transactions. This block only produces the serial clock, the data output value and the data output-enable for the external tri-state pad, and it returns the received value with a one-cycle done pulse.

The serial clock rests high. For every bit the engine first settles the data level with the clock high, waits one half-period, pulls the clock low, waits another half-period and raises it again. The half-period is a whole number of system clock cycles. It is derived from the system clock period and a minimum half-period of 700 ns, rounded upward so that the minimum always holds. The device on the far side only returns meaningful data in the lower half of a read byte, so a read hands back four bits.

Top module: `tw_byte_shifter`

## Requirements
- R1: A write sends bit 7 of `wr_byte` first and bit 0 last. The `sda_o` level is fixed before each falling edge of `sclk_o` and does not change while `sclk_o` is low.
- R2: `sclk_o` is 1 after reset and whenever `busy` is 0. Each byte produces exactly eight low pulses on `sclk_o`.
- R3: Every high wait before a falling edge and every low phase of `sclk_o` lasts exactly HALF_CYC system cycles, where HALF_CYC = ceil(MIN_HALF_NS*1000 / CLK_PERIOD_PS). This is 175 cycles with the defaults.
- R4: On a write, `sda_oe` rises one cycle after the start is accepted, which is before the first falling edge of `sclk_o`. It stays 1 at every falling edge of the byte.
- R5: On a write, `sda_oe` is still 1 when `sclk_o` rises for the eighth time. It drops to 0 in the cycle after `done`, and it is 0 whenever the block is idle.
- R6: A read samples `sda_i` in the last cycle before each falling edge of `sclk_o`. The sampled bits fill byte positions 7 down to 0. `rd_nib` then holds byte bits 3..0, which are the fifth to eighth sampled bits.
- R7: During a read, `sda_oe` stays 0 for the whole byte.
- R8: `busy` rises in the cycle after an accepted start and stays 1 for 16*HALF_CYC+1 cycles. `done` is a single-cycle pulse in the last of those cycles.
- R9: A `start` that arrives while `busy` is 1 is ignored. The running byte keeps its direction, its data and its length, and only one `done` pulse occurs.
- R10: After reset, `busy`, `done` and `sda_oe` are 0 and `sclk_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one byte; accepted only while idle |
| rd_mode | input | 1 | 1 selects a read, 0 selects a write; sampled with start |
| wr_byte | input | 8 | Byte to send on a write; sampled with start |
| sda_i | input | 1 | Level on the data pad |
| sclk_o | output | 1 | Serial clock, idles high |
| sda_o | output | 1 | Data value for the pad driver |
| sda_oe | output | 1 | Pad output-enable, 1 drives the data wire |
| busy | output | 1 | High while a byte is in progress |
| done | output | 1 | One-cycle pulse at the end of a byte |
| rd_nib | output | 4 | Low four bits of the last byte read |

## Verification
On every cycle, the assertions check the following: the clock rests high when idle, the clock never stays low shorter than the half-period, the data stays steady while the clock is low, the pad is enabled at each write falling edge and never during a read, the pad is released right after done, done lasts one cycle, and busy holds through an ignored start. Some things only the bench scenarios can show. These are the bit order on the wire, the exact nibble assembled from a driven read pattern, the exact half-period and byte length in cycles, and the fact that a start during a byte changes neither the bits sent nor the number of done pulses.

// File: rtl/tw_byte_shifter.sv
module tw_byte_shifter #(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int MIN_HALF_NS   = 700
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rd_mode,
  input  logic [7:0] wr_byte,
  input  logic       sda_i,
  output logic       sclk_o,
  output logic       sda_o,
  output logic       sda_oe,
  output logic       busy,
  output logic       done,
  output logic [3:0] rd_nib
);

  localparam int HALF_CYC = (MIN_HALF_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int CW       = $clog2(HALF_CYC + 1);
  localparam int RW       = CW + 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(HALF_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_HIGH, S_LOW, S_FIN} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx;
  logic [7:0]    shreg;
  logic          rd_q, sclk_q, oe_q, sdo_q;
  logic [3:0]    nib_q;

  wire cnt_end = (cnt == '0);

  assign sclk_o = sclk_q;
  assign sda_o  = sdo_q;
  assign sda_oe = oe_q;
  assign busy   = (st != S_IDLE);
  assign done   = (st == S_FIN);
  assign rd_nib = nib_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      shreg  <= '0;
      rd_q   <= 1'b0;
      sclk_q <= 1'b1;
      oe_q   <= 1'b0;
      sdo_q  <= 1'b0;
      nib_q  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          oe_q <= 1'b0;
          if (start) begin
            st    <= S_HIGH;
            cnt   <= CNT_LOAD;
            bidx  <= 3'd7;
            shreg <= wr_byte;
            rd_q  <= rd_mode;
            sdo_q <= rd_mode ? 1'b0 : wr_byte[7];
          end
        end
        S_HIGH: begin
          if (!rd_q) oe_q <= 1'b1;
          if (cnt_end) begin
            if (rd_q) shreg <= {shreg[6:0], sda_i};
            sclk_q <= 1'b0;
            cnt    <= CNT_LOAD;
            st     <= S_LOW;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_LOW: begin
          if (cnt_end) begin
            sclk_q <= 1'b1;
            cnt    <= CNT_LOAD;
            if (bidx == 3'd0) begin
              st <= S_FIN;
              if (rd_q) nib_q <= shreg[3:0];
            end else begin
              bidx <= bidx - 3'd1;
              st   <= S_HIGH;
              if (!rd_q) sdo_q <= shreg[bidx - 3'd1];
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          st    <= S_IDLE;
          oe_q  <= 1'b0;
          sdo_q <= 1'b0;
        end
      endcase
    end
  end

  logic [RW-1:0] lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  lo_run <= '0;
    else if (sclk_q)             lo_run <= '0;
    else if (lo_run != {RW{1'b1}}) lo_run <= lo_run + 1'b1;
  end

  AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_o);                                                  // R2
  AST_LOW_HALF_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> (lo_run >= RW'(HALF_CYC)));                       // R3
  AST_SDO_STABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_o && !$past(sclk_o)) |-> $stable(sda_o));                    // R1
  AST_OE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk_o) && !rd_q) |-> sda_oe);                               // R4
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !sda_oe);                                                  // R5
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_q) |-> !sda_oe);                                        // R7
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                    // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> (busy && $stable(rd_q)));              // R9

endmodule

// File: tb/tw_byte_shifter_test.sv
module tw_byte_shifter_test;
  localparam int HALF = 175;
  localparam int NV   = 6;
  // {rd, data (write byte or read pattern), expected (bus byte or nibble)}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'hA5, 8'hA5}, {1'b0, 8'h01, 8'h01}, {1'b0, 8'h80, 8'h80},
    {1'b1, 8'h3C, 8'h0C}, {1'b1, 8'hF0, 8'h00}, {1'b1, 8'h69, 8'h09}};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rd_mode = 1'b0, sda_i = 1'b0;
  logic [7:0] wr_byte = '0;
  logic sclk_o, sda_o, sda_oe, busy, done;
  logic [3:0] rd_nib;

  tw_byte_shifter uut (.clk(clk), .rst_n(rst_n), .start(start), .rd_mode(rd_mode),
    .wr_byte(wr_byte), .sda_i(sda_i), .sclk_o(sclk_o), .sda_o(sda_o), .sda_oe(sda_oe),
    .busy(busy), .done(done), .rd_nib(rd_nib));

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  logic [7:0] cap, pat;
  logic exp_oe, sclk_prev = 1'b1;
  int nfall, busy_cyc, lo_len, lo_bad, oe_bad, ndone, rise_oe_bad, idle_oe_bad;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cyc++;
      if (done) ndone++;
      if (!busy && sda_oe) idle_oe_bad++;
      if (sclk_prev && !sclk_o) begin
        cap = {cap[6:0], sda_o};
        nfall++;
        if (sda_oe !== exp_oe) oe_bad++;
      end
      if (!sclk_o) lo_len++;
      if (!sclk_prev && sclk_o) begin
        if (lo_len != HALF) lo_bad++;
        if (nfall == 8 && exp_oe && !sda_oe) rise_oe_bad++;
        lo_len = 0;
      end
      sda_i = (nfall < 8) ? pat[7 - nfall] : 1'b0;
      sclk_prev = sclk_o;
    end
  end

  task automatic run(input logic rd, input logic [7:0] d, input bit poke);
    cap = '0; pat = d; nfall = 0; busy_cyc = 0; lo_len = 0; lo_bad = 0;
    oe_bad = 0; ndone = 0; rise_oe_bad = 0; exp_oe = !rd;
    sda_i = d[7];
    @(negedge clk);
    rd_mode = rd; wr_byte = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int w = 0; w < 20000 && busy; w++) begin
      @(negedge clk);
      if (poke && w == 500) begin
        start = 1'b1; rd_mode = !rd; wr_byte = ~d;
      end
      if (poke && w == 501) start = 1'b0;
    end
    if (busy) chk("watchdog", 1, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 sclk in reset", sclk_o, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 oe", sda_oe, 0);
    chk("R10 sclk", sclk_o, 1);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][16], VEC[i][15:8], 1'b0);
      if (VEC[i][16]) begin
        chk("R6 read nibble", rd_nib, VEC[i][3:0]);
        chk("R7 oe during read", oe_bad, 0);
      end else begin
        chk("R1 bits on wire", cap, VEC[i][7:0]);
        chk("R4 oe at falls", oe_bad, 0);
        chk("R5 oe at last rise", rise_oe_bad, 0);
      end
      chk("R2 falling edges", nfall, 8);
      chk("R3 low phase length", lo_bad, 0);
      chk("R8 busy length", busy_cyc, 16 * HALF + 1);
      chk("R8 done pulses", ndone, 1);
      chk("R2 idle clock", sclk_o, 1);
    end

    run(1'b0, 8'h5A, 1'b1);
    chk("R9 byte unchanged", cap, 8'h5A);
    chk("R9 single done", ndone, 1);
    chk("R9 length unchanged", busy_cyc, 16 * HALF + 1);
    run(1'b1, 8'hC3, 1'b1);
    chk("R9 read unchanged", rd_nib, 4'h3);
    chk("R9 read oe", oe_bad, 0);
    chk("R5 oe idle", idle_oe_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule